// File: doc/BRIEF.md
# Scalar Saturating Element-Count Adjuster

This unit executes the scalar-register forms of a vector element-count instruction group. Each cycle it may accept one 32-bit instruction word, the current 64-bit value of the named general register, and an element count. The count has already been resolved upstream from the lane pattern and the element size. The unit multiplies the count by a small immediate (1 to 16). One cycle later it returns the new register value: the bare product, a wrapping step up or down, or a clamped step up or down. The clamped step comes in a signed or unsigned form and in a 32-bit or 64-bit form.

The 32-bit clamped forms still produce a full 64-bit register value. The low word is first widened by zero or sign extension, then stepped, then clamped against the single bound that the step direction can reach. Words outside the group are flagged as illegal, and no write is requested for them. Pattern decoding and register storage stay outside the block.

Top module: `elem_count_adj`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high, and it is low while `rst_ni` is low. In each valid output cycle exactly one of `wr_en_o` and `illegal_o` is high.
- R2: A word is legal only when bits [31:24] are 0x04 and it matches one of the forms in R4 to R9. Otherwise `illegal_o` is raised, `wr_en_o` stays low and `result_o` is zero.
- R3: The step is `count_i` times (bits [19:16] + 1). It is formed without truncation, so a count of 256 with immediate 15 gives 4096.
- R4: Count form (bits [21:20]=10, bits [15:10]=111000): the result is the step, whatever the register value.
- R5: Wrapping form (bits [21:20]=11, bits [15:11]=11100, bit 10 = decrement): the result is the register plus or minus the step, modulo 2^64.
- R6: Clamped 32-bit unsigned form (bits [15:12]=1111, bits [21:20]=10, bit 10=1, bit 11 = decrement). The low word is zero-extended, then stepped. A step up clamps at 0xFFFFFFFF and a step down clamps at 0. A zero step returns the zero-extended word.
- R7: Clamped 32-bit signed form (as R6 with bit 10=0). The low word is sign-extended, then stepped. The result clamps at 2^31-1 going up and at -2^31 going down, and it is always sign-extended to 64 bits.
- R8: Clamped 64-bit unsigned form (bits [21:20]=11, bit 10=1). A step up that carries out gives all ones. A step down larger than the register gives zero. A zero step leaves the register unchanged.
- R9: Clamped 64-bit signed form (bits [21:20]=11, bit 10=0). Overflow going up gives 2^63-1 and overflow going down gives -2^63.
- R10: `rd_o` carries bits [4:0] of the word. Bits [23:22] and [9:5] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is present |
| insn_i | input | 32 | Instruction word |
| count_i | input | 9 | Resolved element count (0 to 256) |
| reg_i | input | 64 | Current value of the destination register |
| valid_o | output | 1 | Result cycle |
| wr_en_o | output | 1 | Write the result to the register |
| illegal_o | output | 1 | Word not in the group |
| rd_o | output | 5 | Destination register index |
| result_o | output | 64 | New register value |

## Verification
In the 32-bit clamped forms, widening of the low word and clamping of the stepped value happen in the same cycle. A bad widening can hide behind a clamp, or a clamp can be taken from the stale upper half. Stimulus therefore puts unrelated non-zero upper halves on registers whose low word sits just inside a bound. The step is chosen to cross that bound in one case and to stay inside it in another. The result is judged against a bench model that widens the word first and then clamps, so garbage in the upper half must never reach the output. Illegal words are placed back to back with legal ones to show that the flag and the write enable never overlap.

// File: rtl/ecnt_pkg.sv
package ecnt_pkg;
  typedef enum logic [2:0] {
    OP_CNT,
    OP_WRAP,
    OP_SAT32,
    OP_SAT64,
    OP_BAD
  } ecnt_op_e;

  typedef struct packed {
    ecnt_op_e   op;
    logic       dec;
    logic       uns;
    logic [3:0] imm;
    logic [4:0] rd;
  } ecnt_dec_t;
endpackage

// File: rtl/ecnt_decode.sv
module ecnt_decode
  import ecnt_pkg::*;
#(
  parameter logic [7:0] GROUP_OP = 8'h04
) (
  input  logic [31:0] insn_i,
  output ecnt_dec_t   dec_o
);
  logic       grp_ok;
  logic [1:0] sel;
  logic [5:0] low;

  assign grp_ok = (insn_i[31:24] == GROUP_OP);
  assign sel    = insn_i[21:20];
  assign low    = insn_i[15:10];

  always_comb begin
    dec_o.op  = OP_BAD;
    dec_o.dec = 1'b0;
    dec_o.uns = 1'b0;
    dec_o.imm = insn_i[19:16];
    dec_o.rd  = insn_i[4:0];
    if (grp_ok && sel[1]) begin
      if (low[5:2] == 4'b1111) begin
        dec_o.op  = sel[0] ? OP_SAT64 : OP_SAT32;
        dec_o.dec = low[1];
        dec_o.uns = low[0];
      end else if (sel[0] && low[5:1] == 5'b11100) begin
        dec_o.op  = OP_WRAP;
        dec_o.dec = low[0];
      end else if (!sel[0] && low == 6'b111000) begin
        dec_o.op = OP_CNT;
      end
    end
  end
endmodule

// File: rtl/ecnt_product.sv
module ecnt_product #(
  parameter int CNT_W  = 9,
  parameter int IMM_W  = 4,
  parameter int PROD_W = CNT_W + IMM_W + 1
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [IMM_W:0] mult;
  assign mult   = {1'b0, imm_i} + 1'b1;
  assign prod_o = PROD_W'(count_i) * PROD_W'(mult);
endmodule

// File: rtl/ecnt_alu.sv
module ecnt_alu
  import ecnt_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int PROD_W = 14
) (
  input  ecnt_op_e          op_i,
  input  logic              dec_i,
  input  logic              uns_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [XLEN-1:0]   res_o
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] U_HALF_MAX = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [XLEN-1:0] S_HALF_MAX = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [XLEN-1:0] S_HALF_MIN = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
  localparam logic [XLEN-1:0] S_FULL_MAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] S_FULL_MIN = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] step, ext, ext_up, ext_dn, full_dn, sat32, sat64;
  logic [XLEN:0]   full_up;

  assign step = XLEN'(prod_i);
  assign ext  = uns_i ? {{HALF{1'b0}}, src_i[HALF-1:0]}
                      : {{HALF{src_i[HALF-1]}}, src_i[HALF-1:0]};

  // Widened word cannot wrap in XLEN bits: one bound check per direction.
  assign ext_up = ext + step;
  assign ext_dn = ext - step;

  always_comb begin
    if (uns_i) begin
      if (dec_i) sat32 = (ext < step) ? '0 : ext_dn;
      else       sat32 = (ext_up > U_HALF_MAX) ? U_HALF_MAX : ext_up;
    end else begin
      if (dec_i) sat32 = ($signed(ext_dn) < $signed(S_HALF_MIN)) ? S_HALF_MIN : ext_dn;
      else       sat32 = ($signed(ext_up) > $signed(S_HALF_MAX)) ? S_HALF_MAX : ext_up;
    end
  end

  assign full_up = {1'b0, src_i} + {1'b0, step};
  assign full_dn = src_i - step;

  always_comb begin
    if (uns_i) begin
      if (dec_i) sat64 = (src_i < step) ? '0 : full_dn;
      else       sat64 = full_up[XLEN] ? '1 : full_up[XLEN-1:0];
    end else begin
      // Step is non-negative: only one overflow direction per operation.
      if (dec_i) sat64 = (src_i[XLEN-1] && !full_dn[XLEN-1]) ? S_FULL_MIN : full_dn;
      else       sat64 = (!src_i[XLEN-1] && full_up[XLEN-1]) ? S_FULL_MAX : full_up[XLEN-1:0];
    end
  end

  always_comb begin
    unique case (op_i)
      OP_CNT:   res_o = step;
      OP_WRAP:  res_o = dec_i ? full_dn : full_up[XLEN-1:0];
      OP_SAT32: res_o = sat32;
      OP_SAT64: res_o = sat64;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/elem_count_adj.sv
module elem_count_adj
  import ecnt_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CNT_W = 9,
  parameter int IMM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [31:0]      insn_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [XLEN-1:0]  reg_i,
  output logic             valid_o,
  output logic             wr_en_o,
  output logic             illegal_o,
  output logic [4:0]       rd_o,
  output logic [XLEN-1:0]  result_o
);
  localparam int PROD_W = CNT_W + IMM_W + 1;

  ecnt_dec_t         dec;
  logic [PROD_W-1:0] prod;
  logic [XLEN-1:0]   res;
  logic              bad;

  ecnt_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  ecnt_product #(.CNT_W(CNT_W), .IMM_W(IMM_W), .PROD_W(PROD_W)) u_prod (
    .count_i (count_i),
    .imm_i   (dec.imm[IMM_W-1:0]),
    .prod_o  (prod)
  );

  ecnt_alu #(.XLEN(XLEN), .PROD_W(PROD_W)) u_alu (
    .op_i   (dec.op),
    .dec_i  (dec.dec),
    .uns_i  (dec.uns),
    .src_i  (reg_i),
    .prod_i (prod),
    .res_o  (res)
  );

  assign bad = (dec.op == OP_BAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_o      <= '0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      wr_en_o   <= valid_i && !bad;
      illegal_o <= valid_i && bad;
      if (valid_i) begin
        rd_o     <= dec.rd;
        result_o <= res;
      end
    end
  end
endmodule

// File: rtl/elem_count_adj_chk.sv
module elem_count_adj_chk #(
  parameter int XLEN  = 64,
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [31:0]      insn_i,
  input logic [CNT_W-1:0] count_i,
  input logic [XLEN-1:0]  reg_i,
  input logic             valid_o,
  input logic             wr_en_o,
  input logic             illegal_o,
  input logic [XLEN-1:0]  result_o
);
  localparam int HALF = XLEN / 2;

  logic in_grp, is_cnt, is_s32u, is_s32s, is_s64u_inc;
  assign in_grp      = insn_i[31:24] == 8'h04;
  assign is_cnt      = in_grp && insn_i[21:20] == 2'b10 && insn_i[15:10] == 6'b111000;
  assign is_s32u     = in_grp && insn_i[21:20] == 2'b10 && insn_i[15:12] == 4'b1111 && insn_i[10];
  assign is_s32s     = in_grp && insn_i[21:20] == 2'b10 && insn_i[15:12] == 4'b1111 && !insn_i[10];
  assign is_s64u_inc = in_grp && insn_i[21:20] == 2'b11 && insn_i[15:10] == 6'b111101;

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r1_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones({wr_en_o, illegal_o}) == 1);
  a_r2_bad_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_grp) |=> (illegal_o && !wr_en_o && result_o == '0));
  a_r4_count_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_cnt) |=>
      result_o == XLEN'($past(count_i)) * (XLEN'($past(insn_i[19:16])) + XLEN'(1)));
  a_r6_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_s32u) |=> result_o[XLEN-1:HALF] == '0);
  a_r7_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_s32s) |=> result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}});
  a_r8_no_shrink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_s64u_inc) |=> result_o >= $past(reg_i));
endmodule

bind elem_count_adj elem_count_adj_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .insn_i    (insn_i),
  .count_i   (count_i),
  .reg_i     (reg_i),
  .valid_o   (valid_o),
  .wr_en_o   (wr_en_o),
  .illegal_o (illegal_o),
  .result_o  (result_o)
);

// File: tb/elem_count_adj_tb_top.sv
module elem_count_adj_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [8:0]  count_i = '0;
  logic [63:0] reg_i = '0;
  logic        valid_o, wr_en_o, illegal_o;
  logic [4:0]  rd_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [69:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  elem_count_adj dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .count_i(count_i), .reg_i(reg_i), .valid_o(valid_o), .wr_en_o(wr_en_o),
    .illegal_o(illegal_o), .rd_o(rd_o), .result_o(result_o)
  );

  localparam logic [5:0] L_CNT = 6'b111000;

  function automatic logic [31:0] enc(input logic [7:0] top, input logic [1:0] esz,
                                      input logic [1:0] sel, input logic [3:0] imm,
                                      input logic [5:0] low, input logic [4:0] pat,
                                      input logic [4:0] rd);
    return {top, esz, sel, imm, low, pat, rd};
  endfunction

  // Reference: returns {illegal, result}
  function automatic logic [64:0] model(input logic [31:0] w, input logic [8:0] c,
                                        input logic [63:0] r);
    logic signed [67:0] p, x, y;
    logic [5:0] low;
    logic [1:0] sel;
    p   = 68'(c) * (68'(w[19:16]) + 68'sd1);
    low = w[15:10];
    sel = w[21:20];
    if (w[31:24] != 8'h04 || !sel[1]) return {1'b1, 64'd0};
    if (low[5:2] == 4'b1111) begin
      if (!sel[0]) x = low[0] ? $signed({36'd0, r[31:0]}) : 68'($signed(r[31:0]));
      else         x = low[0] ? $signed({4'd0, r}) : 68'($signed(r));
      y = low[1] ? x - p : x + p;
      if (!sel[0]) begin
        if (low[0]) begin
          if (y < 0) y = 0;
          if (y > 68'sd4294967295) y = 68'sd4294967295;
        end else begin
          if (y > 68'sd2147483647) y = 68'sd2147483647;
          if (y < -68'sd2147483648) y = -68'sd2147483648;
        end
      end else begin
        if (low[0]) begin
          if (y < 0) y = 0;
          if (y > $signed({4'd0, 64'hFFFF_FFFF_FFFF_FFFF})) y = $signed({4'd0, 64'hFFFF_FFFF_FFFF_FFFF});
        end else begin
          if (y > $signed({4'd0, 64'h7FFF_FFFF_FFFF_FFFF})) y = $signed({4'd0, 64'h7FFF_FFFF_FFFF_FFFF});
          if (y < $signed({4'hF, 64'h8000_0000_0000_0000})) y = $signed({4'hF, 64'h8000_0000_0000_0000});
        end
      end
      return {1'b0, y[63:0]};
    end
    if (sel[0] && low[5:1] == 5'b11100) return {1'b0, low[0] ? r - p[63:0] : r + p[63:0]};
    if (!sel[0] && low == L_CNT) return {1'b0, p[63:0]};
    return {1'b1, 64'd0};
  endfunction

  task automatic drive(input logic [31:0] w, input logic [8:0] c, input logic [63:0] r,
                       input string tag);
    logic [64:0] m;
    @(negedge clk);
    valid_i = 1'b1; insn_i = w; count_i = c; reg_i = r;
    m = model(w, c, r);
    exp_q.push_back({m[64], w[4:0], m[63:0]});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; insn_i = $urandom; reg_i = {$urandom, $urandom};
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        logic [69:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected valid_o: actual=1 expected=0");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (illegal_o !== e[69] || wr_en_o !== !e[69] || rd_o !== e[68:64] ||
              result_o !== e[63:0]) begin
            errors++;
            $display("FAIL %s: actual ill=%0b we=%0b rd=%0d res=%h expected ill=%0b we=%0b rd=%0d res=%h",
                     t, illegal_o, wr_en_o, rd_o, result_o, e[69], !e[69], e[68:64], e[63:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || wr_en_o !== 1'b0 || illegal_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual valid=%0b expected 0", valid_o);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: actual=%0b expected=0", valid_o);
    end

    // R3 / R4 count form, product without truncation
    drive(enc(8'h04, 2'd0, 2'b10, 4'hF, L_CNT, 5'd0, 5'd7), 9'd256, 64'hDEAD_BEEF_0000_1111, "R3");
    drive(enc(8'h04, 2'd1, 2'b10, 4'h2, L_CNT, 5'd3, 5'd1), 9'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    // R5 wrapping
    drive(enc(8'h04, 2'd2, 2'b11, 4'h1, 6'b111000, 5'd0, 5'd2), 9'd4, 64'hFFFF_FFFF_FFFF_FFFE, "R5");
    drive(enc(8'h04, 2'd2, 2'b11, 4'h0, 6'b111001, 5'd0, 5'd3), 9'd5, 64'd3, "R5");
    idle(1);
    // R6 32-bit unsigned: garbage upper half
    drive(enc(8'h04, 2'd0, 2'b10, 4'h1, 6'b111101, 5'd0, 5'd4), 9'd16, 64'hDEAD_BEEF_FFFF_FFF0, "R6");
    drive(enc(8'h04, 2'd0, 2'b10, 4'h1, 6'b111111, 5'd0, 5'd4), 9'd5, 64'hA5A5_A5A5_0000_0005, "R6");
    drive(enc(8'h04, 2'd0, 2'b10, 4'h0, 6'b111101, 5'd0, 5'd4), 9'd8, 64'h1234_5678_0000_0064, "R6");
    drive(enc(8'h04, 2'd0, 2'b10, 4'h7, 6'b111111, 5'd0, 5'd4), 9'd0, 64'h1234_5678_9ABC_DEF0, "R6");
    // R7 32-bit signed
    drive(enc(8'h04, 2'd1, 2'b10, 4'h1, 6'b111100, 5'd0, 5'd5), 9'd16, 64'h0F0F_0000_7FFF_FFF0, "R7");
    drive(enc(8'h04, 2'd1, 2'b10, 4'h1, 6'b111110, 5'd0, 5'd5), 9'd5, 64'h0000_1111_8000_0005, "R7");
    drive(enc(8'h04, 2'd1, 2'b10, 4'h0, 6'b111100, 5'd0, 5'd5), 9'd5, 64'h7777_0000_FFFF_FFFE, "R7");
    drive(enc(8'h04, 2'd1, 2'b10, 4'h3, 6'b111110, 5'd0, 5'd5), 9'd0, 64'h0000_0000_8000_0001, "R7");
    // R8 64-bit unsigned
    drive(enc(8'h04, 2'd3, 2'b11, 4'h1, 6'b111101, 5'd0, 5'd6), 9'd16, 64'hFFFF_FFFF_FFFF_FFF0, "R8");
    drive(enc(8'h04, 2'd3, 2'b11, 4'h1, 6'b111111, 5'd0, 5'd6), 9'd5, 64'd5, "R8");
    drive(enc(8'h04, 2'd3, 2'b11, 4'h0, 6'b111111, 5'd0, 5'd6), 9'd8, 64'd100, "R8");
    drive(enc(8'h04, 2'd3, 2'b11, 4'h9, 6'b111101, 5'd0, 5'd6), 9'd0, 64'hCAFE_0000_1234_5678, "R8");
    // R9 64-bit signed
    drive(enc(8'h04, 2'd3, 2'b11, 4'h1, 6'b111100, 5'd0, 5'd8), 9'd16, 64'h7FFF_FFFF_FFFF_FFF0, "R9");
    drive(enc(8'h04, 2'd3, 2'b11, 4'h1, 6'b111110, 5'd0, 5'd8), 9'd5, 64'h8000_0000_0000_0005, "R9");
    drive(enc(8'h04, 2'd3, 2'b11, 4'h0, 6'b111100, 5'd0, 5'd8), 9'd5, 64'hFFFF_FFFF_FFFF_FFFE, "R9");
    // R2 illegal words interleaved with legal ones
    drive(enc(8'h05, 2'd0, 2'b10, 4'h1, L_CNT, 5'd0, 5'd9), 9'd4, 64'd1, "R2");
    drive(enc(8'h04, 2'd0, 2'b10, 4'h1, 6'b111001, 5'd0, 5'd9), 9'd4, 64'd1, "R2");
    drive(enc(8'h04, 2'd0, 2'b11, 4'h1, 6'b111000, 5'd0, 5'd9), 9'd4, 64'd1, "R5");
    drive(enc(8'h04, 2'd0, 2'b01, 4'h1, 6'b111101, 5'd0, 5'd9), 9'd4, 64'd1, "R2");
    // R10 esz and pattern fields do not change the result; rd passes through
    drive(enc(8'h04, 2'd0, 2'b11, 4'h2, 6'b111101, 5'd0,  5'd31), 9'd7, 64'd1000, "R10");
    drive(enc(8'h04, 2'd3, 2'b11, 4'h2, 6'b111101, 5'd31, 5'd17), 9'd7, 64'd1000, "R10");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results: actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule